// File: doc/BRIEF.md
# Probe-Pair Window Match Scorer

The block scores how well a fixed 16x16 window at every position of an image matches a target outline described by a set of probes. A probe names two pixel positions inside the window, one on each side of the outline. It fires when the first pixel minus the second, taken as a signed difference, is strictly larger than a programmable threshold. For each window the block adds up the firing probes and reports that count together with the count as a whole-number percentage of the active probe set.

Before a frame, software loads the probe table, the threshold and the number of active probes through a single write port. These values are held in a staging copy and move into the working copy only when a start-of-frame pulse arrives, so a frame is always scored with one consistent configuration. Pixels then arrive in raster order, one per accepted cycle. Each position where the window lies wholly inside the image gives one score, and scores leave in raster order of the window's top-left corner.

Top module: `prb_scorer`

## Requirements
- R1: While reset is held and in the first cycle after it, `score_vld` is 0 and `score` and `score_pct` are 0.
- R2: Write addresses 0 to N_PROBES-1 load a probe entry with bits [15:12] = first row, [11:8] = first column, [7:4] = second row, [3:0] = second column (row 0 and column 0 are the window's top-left). Address N_PROBES loads the threshold from bits [7:0]. Address N_PROBES+1 loads the active probe count from bits [5:0], and a count above N_PROBES is clamped to N_PROBES.
- R3: A probe fires only when (first pixel − second pixel), as a signed value, is strictly greater than the unsigned 8-bit threshold. A difference equal to the threshold does not fire.
- R4: `score` equals the number of firing probes among entries 0 to count-1. Entries at or above the active count never contribute.
- R5: `score_pct` equals floor(score × 100 / count), and is 0 when the count is 0.
- R6: Each frame of IMG_W × IMG_H pixels yields exactly (IMG_W−15) × (IMG_H−15) scores. Windows that would cross the right or bottom edge give none, and scores come in raster order of the top-left corner.
- R7: Configuration writes take effect only at the next `sof` pulse. A write in the middle of a frame does not change that frame's scores. A write in the same cycle as `sof` applies from the frame after the one it starts.
- R8: Pixels offered before the first `sof` after reset, or after the last pixel of a frame, are dropped. They produce no score and leave the next frame unaffected.
- R9: An `sof` pulse in the middle of a frame restarts the raster position at the top-left pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse; commits staged configuration |
| pix_vld | input | 1 | Pixel present this cycle |
| pix | input | PW | Pixel value, raster order |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| score_vld | output | 1 | A window score is present |
| score | output | CW | Number of firing probes |
| score_pct | output | 7 | Score as percent of active probe count |

## Verification
The interesting collision is a configuration write landing in the same cycle as the `sof` that commits staged values, and also a write arriving in the middle of a frame while scores for that frame are still being produced. The bench drives a threshold write during pixel streaming and a count write together with `sof`. It then predicts each following frame from a model in which the committed copy takes the old staged value and the new write becomes visible only one frame later. Every score and percentage is compared in arrival order against that prediction, so a design that commits the concurrent write too early produces wrong counts in that frame.

// File: rtl/prb_pkg.sv
// Shared constants and the probe entry layout for the probe scorer.
// Assumes a 16x16 window addressed by 4-bit row and column offsets.
package prb_pkg;
    localparam int OFS_W  = 4;
    localparam int WIN    = 1 << OFS_W;
    localparam int CFG_DW = 16;

    typedef struct packed {
        logic [OFS_W-1:0] r1;
        logic [OFS_W-1:0] c1;
        logic [OFS_W-1:0] r2;
        logic [OFS_W-1:0] c2;
    } probe_t;
endpackage

// File: rtl/prb_table.sv
// Probe table with a staging copy written by software and a working copy
// that is refreshed from staging on each start-of-frame pulse.
// Assumes the count register never needs more than CW bits.
module prb_table
    import prb_pkg::*;
#(
    parameter int N  = 36,
    parameter int AW = 6,
    parameter int CW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output probe_t            act_probe [N],
    output logic [7:0]        act_thr,
    output logic [CW-1:0]     act_cnt
);
    localparam logic [AW-1:0] THR_ADDR = AW'(N);
    localparam logic [AW-1:0] CNT_ADDR = AW'(N + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(N);

    probe_t        stg_probe [N];
    logic [7:0]    stg_thr;
    logic [CW-1:0] stg_cnt;
    logic [CW-1:0] wr_cnt;

    // Clamp a written count to the table size.
    always_comb begin
        wr_cnt = cfg_wdata[CW-1:0];
        if (wr_cnt > CNT_MAX) wr_cnt = CNT_MAX;
    end

    // Staging copy: software writes land here at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) stg_probe[i] <= '0;
            stg_thr <= '0;
            stg_cnt <= '0;
        end else if (cfg_we) begin
            if (cfg_addr < THR_ADDR)       stg_probe[cfg_addr] <= probe_t'(cfg_wdata);
            else if (cfg_addr == THR_ADDR) stg_thr <= cfg_wdata[7:0];
            else if (cfg_addr == CNT_ADDR) stg_cnt <= wr_cnt;
        end
    end

    // Working copy: takes the staged values present before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) act_probe[i] <= '0;
            act_thr <= '0;
            act_cnt <= '0;
        end else if (sof) begin
            act_probe <= stg_probe;
            act_thr   <= stg_thr;
            act_cnt   <= stg_cnt;
        end
    end
endmodule

// File: rtl/prb_window.sv
// Raster-position tracker and pixel history. A shift line of
// (WIN-1) rows plus WIN pixels exposes the full WIN x WIN window whose
// bottom-right pixel is the newest. Assumes IMG_W >= WIN, IMG_H >= WIN.
module prb_window
    import prb_pkg::*;
#(
    parameter int IMG_W = 24,
    parameter int IMG_H = 20,
    parameter int PW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    input  logic          pix_vld,
    input  logic [PW-1:0] pix,
    output logic [PW-1:0] win [WIN*WIN],
    output logic          win_vld
);
    localparam int SR_LEN = (WIN - 1) * IMG_W + WIN;
    localparam int XW     = $clog2(IMG_W);
    localparam int YW     = $clog2(IMG_H);

    logic [PW-1:0] line [SR_LEN];
    logic [XW-1:0] col;
    logic [YW-1:0] row;
    logic          active;
    logic          accept;

    assign accept = pix_vld && active && !sof;

    // Pixel history: data only, no reset needed.
    always_ff @(posedge clk) begin
        if (accept) begin
            line[0] <= pix;
            for (int i = 1; i < SR_LEN; i++) line[i] <= line[i-1];
        end
    end

    // Raster position and frame-active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0; row <= '0; active <= 1'b0;
        end else if (sof) begin
            col <= '0; row <= '0; active <= 1'b1;
        end else if (accept) begin
            if (col == XW'(IMG_W - 1)) begin
                col <= '0;
                row <= row + 1'b1;
                if (row == YW'(IMG_H - 1)) active <= 1'b0;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // A window is complete when its bottom-right pixel is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) win_vld <= 1'b0;
        else        win_vld <= accept && (row >= YW'(WIN - 1)) && (col >= XW'(WIN - 1));
    end

    for (genvar r = 0; r < WIN; r++) begin : g_row
        for (genvar c = 0; c < WIN; c++) begin : g_col
            assign win[r*WIN + c] = line[(WIN-1-r)*IMG_W + (WIN-1-c)];
        end
    end
endmodule

// File: rtl/prb_eval.sv
// One comparator per probe: signed pixel difference against the threshold,
// gated by the active probe count. Purely combinational.
module prb_eval
    import prb_pkg::*;
#(
    parameter int N  = 36,
    parameter int PW = 8,
    parameter int CW = 6
) (
    input  logic [PW-1:0] win [WIN*WIN],
    input  probe_t        probe [N],
    input  logic [7:0]    thr,
    input  logic [CW-1:0] cnt,
    output logic [N-1:0]  fire
);
    localparam int DW = (PW > 8 ? PW : 8) + 2;

    for (genvar p = 0; p < N; p++) begin : g_probe
        localparam logic [CW-1:0] IDX = CW'(p);
        logic [PW-1:0]        pa, pb;
        logic signed [DW-1:0] diff;
        assign pa   = win[{probe[p].r1, probe[p].c1}];
        assign pb   = win[{probe[p].r2, probe[p].c2}];
        assign diff = $signed(DW'(pa)) - $signed(DW'(pb));
        assign fire[p] = (diff > $signed(DW'(thr))) && (IDX < cnt);
    end
endmodule

// File: rtl/prb_sum_tree.sv
// Pipelined population count: level 0 registers the fire bits, each
// further level registers pairwise sums. Latency is clog2(N)+1 cycles.
// Assumes N >= 2 and 2**CW > N.
module prb_sum_tree #(
    parameter int N  = 36,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [N-1:0]  bits,
    output logic          out_vld,
    output logic [CW-1:0] sum
);
    localparam int L = $clog2(N);
    localparam int P = 1 << L;

    logic [P-1:0]  pad;
    logic [CW-1:0] node [L+1][P];
    logic [L:0]    vld;

    assign pad = P'(bits);

    // All tree levels and the matching valid pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int lv = 0; lv <= L; lv++)
                for (int i = 0; i < P; i++) node[lv][i] <= '0;
        end else begin
            vld <= {vld[L-1:0], in_vld};
            for (int i = 0; i < P; i++) node[0][i] <= CW'(pad[i]);
            for (int lv = 1; lv <= L; lv++)
                for (int i = 0; i < P / 2; i++)
                    if (i < (P >> lv))
                        node[lv][i] <= node[lv-1][2*i] + node[lv-1][2*i+1];
        end
    end

    assign out_vld = vld[L];
    assign sum     = node[L][0];
endmodule

// File: rtl/prb_scorer.sv
// Probe-pair window match scorer top. Chains window store, probe
// comparators and sum tree, then registers count and percentage.
// Assumes sof is not pulsed while scores of the previous frame are still
// in the pipeline (about clog2(N)+3 cycles after its last pixel).
module prb_scorer
    import prb_pkg::*;
#(
    parameter int IMG_W    = 24,
    parameter int IMG_H    = 20,
    parameter int PW       = 8,
    parameter int N_PROBES = 36,
    localparam int AW      = $clog2(N_PROBES + 2),
    localparam int CW      = $clog2(N_PROBES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              pix_vld,
    input  logic [PW-1:0]     pix,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              score_vld,
    output logic [CW-1:0]     score,
    output logic [6:0]        score_pct
);
    localparam int MW = CW + 7;

    probe_t              act_probe [N_PROBES];
    logic [7:0]          act_thr;
    logic [CW-1:0]       act_cnt;
    logic [PW-1:0]       win [WIN*WIN];
    logic                win_vld;
    logic [N_PROBES-1:0] fire;
    logic                tree_vld;
    logic [CW-1:0]       tree_sum;
    logic [MW-1:0]       num, quo;

    prb_table #(.N(N_PROBES), .AW(AW), .CW(CW)) u_tab (
        .clk(clk), .rst_n(rst_n), .sof(sof), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .act_probe(act_probe), .act_thr(act_thr), .act_cnt(act_cnt));

    prb_window #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PW(PW)) u_win (
        .clk(clk), .rst_n(rst_n), .sof(sof), .pix_vld(pix_vld), .pix(pix),
        .win(win), .win_vld(win_vld));

    prb_eval #(.N(N_PROBES), .PW(PW), .CW(CW)) u_eval (
        .win(win), .probe(act_probe), .thr(act_thr), .cnt(act_cnt), .fire(fire));

    prb_sum_tree #(.N(N_PROBES), .CW(CW)) u_tree (
        .clk(clk), .rst_n(rst_n), .in_vld(win_vld), .bits(fire),
        .out_vld(tree_vld), .sum(tree_sum));

    // Percentage of the active probe set, rounded down.
    always_comb begin
        num = MW'(tree_sum) * MW'(100);
        quo = (act_cnt == '0) ? '0 : num / MW'(act_cnt);
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score_vld <= 1'b0; score <= '0; score_pct <= '0;
        end else begin
            score_vld <= tree_vld;
            score     <= tree_vld ? tree_sum : '0;
            score_pct <= tree_vld ? quo[6:0] : '0;
        end
    end
endmodule

// File: rtl/prb_scorer_chk.sv
// Property checker for the scorer outputs; attached by bind below.
// Assumes N is the probe table size of the bound instance.
module prb_scorer_chk #(
    parameter int N  = 36,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sof,
    input logic          score_vld,
    input logic [CW-1:0] score,
    input logic [6:0]    score_pct
);
    logic seen_sof;

    // Remember whether any frame has started since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   seen_sof <= 1'b0;
        else if (sof) seen_sof <= 1'b1;
    end

    AST_PCT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        score_vld |-> score_pct <= 7'd100);                          // R5
    AST_SCORE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        score_vld |-> score <= CW'(N));                              // R4
    AST_ZERO_PCT: assert property (@(posedge clk) disable iff (!rst_n)
        (score_vld && score == '0) |-> score_pct == '0);             // R5
    AST_NONZERO_PCT: assert property (@(posedge clk) disable iff (!rst_n)
        (score_vld && score != '0) |-> score_pct != '0);             // R5
    AST_NO_FRAME_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sof |-> !score_vld);                                   // R8
endmodule

bind prb_scorer prb_scorer_chk #(.N(N_PROBES), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sof(sof), .score_vld(score_vld),
    .score(score), .score_pct(score_pct));

// File: tb/prb_scorer_tb.sv
// Frame-level bench: a model of staged/working configuration predicts
// every window score, which is compared in arrival order.
module prb_scorer_tb;
    localparam int IW = 24, IH = 20, N = 36, CW = 6, AW = 6;
    localparam int NX = IW - 15, NY = IH - 15;

    logic          clk = 1'b0, rst_n = 1'b0, sof = 1'b0, pix_vld = 1'b0, cfg_we = 1'b0;
    logic [7:0]    pix = '0;
    logic [AW-1:0] cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          score_vld;
    logic [CW-1:0] score;
    logic [6:0]    score_pct;

    prb_scorer #(.IMG_W(IW), .IMG_H(IH), .PW(8), .N_PROBES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .sof(sof), .pix_vld(pix_vld), .pix(pix),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .score_vld(score_vld), .score(score), .score_pct(score_pct));

    always #5 clk = ~clk;

    int total = 0, bad = 0, got = 0;
    bit done = 0;
    string tag = "R4";
    logic [15:0] sh_e [N], act_e [N];
    int sh_thr = 0, act_thr = 0, sh_cnt = 0, act_cnt = 0;
    int img [IH][IW];
    int exp_s [$], exp_p [$];

    task automatic check(bit ok, string req, int act, int expv, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Compare each arriving score against the prediction queue.
    always @(negedge clk) begin
        if (rst_n && score_vld) begin
            got++;
            if (exp_s.size() == 0) check(0, "R6", 1, 0, "unexpected score");
            else begin
                int es, ep;
                es = exp_s.pop_front(); ep = exp_p.pop_front();
                check(score == CW'(es), tag, score, es, "score");
                check(score_pct == 7'(ep), "R5", score_pct, ep, "percent");
            end
        end
    end

    task automatic stage(int a, logic [15:0] d);
        if (a < N) sh_e[a] = d;
        else if (a == N) sh_thr = d[7:0];
        else if (a == N + 1) sh_cnt = (d[5:0] > N) ? N : d[5:0];
    endtask

    task automatic cfg_write(int a, logic [15:0] d);
        @(posedge clk); #1 cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d;
        @(posedge clk); #1 cfg_we = 0;
        stage(a, d);
    endtask

    // Start a frame; optionally with a write in the same cycle (R7).
    task automatic do_sof(bit wr, int a, logic [15:0] d);
        @(posedge clk); #1 sof = 1;
        if (wr) begin cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = d; end
        @(posedge clk); #1 sof = 0; cfg_we = 0;
        act_e = sh_e; act_thr = sh_thr; act_cnt = sh_cnt;
        if (wr) stage(a, d);
    endtask

    task automatic build(int mode, int f);
        for (int y = 0; y < IH; y++)
            for (int x = 0; x < IW; x++)
                case (mode)
                    0: img[y][x] = (x*37 + y*11 + f*53) % 256;
                    1: img[y][x] = 8*x + y;
                    default: img[y][x] = ((x*x + 3*y*y + f) * 29) % 256;
                endcase
    endtask

    task automatic predict();
        for (int wy = 0; wy < NY; wy++)
            for (int wx = 0; wx < NX; wx++) begin
                int s = 0;
                for (int p = 0; p < act_cnt; p++) begin
                    logic [15:0] e = act_e[p];
                    int a = img[wy + e[15:12]][wx + e[11:8]];
                    int b = img[wy + e[7:4]][wx + e[3:0]];
                    if (a - b > act_thr) s++;
                end
                exp_s.push_back(s);
                exp_p.push_back(act_cnt == 0 ? 0 : s * 100 / act_cnt);
            end
    endtask

    // Stream npix pixels of img; optional mid-frame config write.
    task automatic stream(int npix, bit gaps, int wr_at, int wa, logic [15:0] wd);
        for (int k = 0; k < npix; k++) begin
            int y = (k / IW) % IH, x = k % IW;
            if (gaps && ((x + 3*y) % 7 == 2)) begin
                @(posedge clk); #1 pix_vld = 0;
            end
            @(posedge clk); #1 pix_vld = 1; pix = 8'(img[y][x]);
            if (k == wr_at) begin cfg_we = 1; cfg_addr = AW'(wa); cfg_wdata = wd; end
            else cfg_we = 0;
            if (k == wr_at) stage(wa, wd);
        end
        @(posedge clk); #1 pix_vld = 0; cfg_we = 0;
    endtask

    task automatic drain_check(string req);
        repeat (20) @(posedge clk);
        #2;
        check(exp_s.size() == 0, req, exp_s.size(), 0, "scores missing");
        check(got == NX*NY, "R6", got, NX*NY, "score count per frame");
    endtask

    task automatic frame(int mode, int f, bit gaps, int wr_at, int wa, logic [15:0] wd, int extra);
        got = 0;
        build(mode, f);
        predict();
        stream(IW*IH + extra, gaps, wr_at, wa, wd);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        check(score_vld == 0 && score == 0 && score_pct == 0, "R1", score_vld, 0, "reset outputs");
        @(posedge clk); #1 rst_n = 1;
        #2;
        check(score_vld == 0, "R1", score_vld, 0, "first cycle after reset");

        // R8: pixels before any sof are dropped.
        build(0, 7); got = 0;
        stream(IW*IH, 0, -1, 0, 0);
        repeat (20) @(posedge clk);
        check(got == 0, "R8", got, 0, "scores before first frame");

        // R2/R4: general table, thr 20, 35 active probes.
        for (int p = 0; p < N; p++)
            cfg_write(p, {4'((p*5+1)%16), 4'((p*3)%16), 4'((p*7+4)%16), 4'((p*11+2)%16)});
        cfg_write(N, 16'd20);
        cfg_write(N + 1, 16'd35);
        do_sof(0, 0, 0); tag = "R4";
        frame(0, 1, 1, -1, 0, 0, 0); drain_check("R4");

        // R3: diffs 7/8/9 against threshold 8; mid-frame thr write (R7).
        for (int p = 0; p < N; p++) begin
            int c2 = p % 15, r2 = p % 14 + 1;
            cfg_write(p, {4'(r2 + p%3 - 1), 4'(c2 + 1), 4'(r2), 4'(c2)});
        end
        cfg_write(N, 16'd8);
        cfg_write(N + 1, 16'd36);
        do_sof(0, 0, 0); tag = "R3";
        frame(1, 0, 0, 200, N, 16'd100, 0); drain_check("R3");

        // R7: count write together with sof goes to the following frame.
        do_sof(1, N + 1, 16'd10); tag = "R7";
        check(act_cnt == 36 && act_thr == 100, "R7", act_cnt, 36, "model commit");
        frame(2, 3, 1, -1, 0, 0, 0); drain_check("R7");

        // R7 and R8: count 10 now active; extra trailing pixels dropped.
        do_sof(0, 0, 0); tag = "R7";
        frame(0, 4, 0, -1, 0, 0, 30); drain_check("R8");

        // R5: zero active probes gives zero scores and zero percent.
        cfg_write(N + 1, 16'd0);
        do_sof(0, 0, 0); tag = "R5";
        frame(2, 5, 0, -1, 0, 0, 0); drain_check("R5");

        // R2: count above table size clamps; threshold 0.
        cfg_write(N + 1, 16'd63);
        cfg_write(N, 16'd0);
        do_sof(0, 0, 0); tag = "R2";
        frame(2, 6, 1, -1, 0, 0, 0); drain_check("R2");

        // R9: aborted partial frame, then restart.
        do_sof(0, 0, 0);
        build(0, 9); got = 0;
        stream(300, 0, -1, 0, 0);
        do_sof(0, 0, 0); tag = "R9";
        frame(1, 0, 1, -1, 0, 0, 0); drain_check("R9");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R6 watchdog expired: got 0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule